// File: doc/BRIEF.md
# Configuration Address/Data Port Decoder

This block sits on the host side of a configuration fabric. Software reaches device configuration registers indirectly through two I/O ports. First it writes a 32-bit configuration address into an address port. It then reads or writes a four-byte data window, and each such access is forwarded to the device that the latched address names. The block decodes the enable flag, bus number, device/function number and register offset from the latched address. It validates every data access against those fields and against a presence vector, one bit per device/function slot on bus 0.

A valid access produces a registered target strobe one clock after the port access. The strobe carries the slot, a byte-level register offset, the byte count, the write data and the direction. The selected target answers a read on a shared return bus while the strobe is high, and the block returns that word on the I/O side one clock later. A data read that fails validation still completes, with a value of zero. A data write that fails validation is dropped.

Top module: `cfgp_decoder`

## Requirements
- R1: The address port is the 32-bit register at I/O address 0xCF8 and resets to 0. A write with io_addr = 0xCF8 and io_len = 4 loads io_wdata into it. A read at any address from 0xCF8 to 0xCFB returns its value, sampled in the request cycle, with io_rvalid two cycles after io_rd.
- R2: A write to 0xCF8 with io_len of 1 or 2 leaves the address register unchanged.
- R3: The data window covers 0xCFC to 0xCFF. io_len is a byte count, and only the values 1, 2 and 4 are legal. An access with any other length, or one whose io_addr[1:0] + io_len exceeds 4, fails validation.
- R4: A data access fails validation unless bit 31 of the address register is 1.
- R5: A data access fails validation when bits 1:0 of the address register are nonzero.
- R6: Address register bits 23:16 give the bus number and bits 15:8 give the device/function slot. A data access fails validation unless the bus is 0 and slot_present[slot] is 1.
- R7: A valid data access raises tgt_req for one cycle, starting the cycle after the access. With it come tgt_wr (1 for a write), tgt_slot, tgt_len, tgt_wdata, and tgt_off = {address register bits 7:2, io_addr[1:0]}.
- R8: For a valid data read, io_rvalid rises two cycles after io_rd. io_rdata then holds the value of tgt_rdata from the cycle in which tgt_req was high. Back-to-back reads return in order.
- R9: A data read that fails validation returns io_rvalid with io_rdata = 0. A data write that fails validation raises no tgt_req.
- R10: A read outside 0xCF8 to 0xCFF produces no io_rvalid. An access with io_wr and io_rd both high is handled as a write only and produces no io_rvalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | IO_AW | I/O port address |
| io_wdata | input | 32 | I/O write data |
| io_len | input | 3 | Access size in bytes (1, 2 or 4) |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| slot_present | input | 256 | Presence bit per device/function slot on bus 0 |
| io_rdata | output | 32 | Read return data |
| io_rvalid | output | 1 | Read return valid |
| tgt_req | output | 1 | Target access strobe |
| tgt_wr | output | 1 | Target access is a write |
| tgt_slot | output | 8 | Selected device/function slot |
| tgt_off | output | 8 | Byte-level register offset |
| tgt_len | output | 3 | Byte count of the target access |
| tgt_wdata | output | 32 | Write data to the target |
| tgt_rdata | input | 32 | Read data from the selected target |

## Verification
The bench goes after the validation corners one at a time.
- It clears the enable bit, sets a low address bit, names bus 1, and names a slot with no device present.
- A design that skipped one of these checks would raise tgt_req there, or return target data where zero is required.

It uses halfword accesses to offsets 2 and 3 and an illegal length of 3. A decoder that ignored the window fit or the length would forward a straddling access. It also writes bytes and halfwords to the address port. A design that latched partial writes would change the value read back. Consecutive data reads, reads of foreign addresses and combined read/write strobes expose a return pipeline that reorders results, drops them, or answers where it must stay silent.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SLOT_W  = 8;
  localparam int unsigned BUS_W   = 8;
  localparam int unsigned OFF_W   = 8;
  localparam int unsigned LEN_W   = 3;
  localparam int unsigned NUM_SLOTS = 1 << SLOT_W;

  localparam logic [15:0] ADDR_PORT = 16'h0CF8;
  localparam logic [15:0] DATA_PORT = 16'h0CFC;

  typedef enum logic [1:0] {
    RK_NONE  = 2'd0,
    RK_ADDR  = 2'd1,
    RK_CLAIM = 2'd2,
    RK_NULL  = 2'd3
  } rd_kind_e;
endpackage

// File: rtl/cfgp_addr_reg.sv
module cfgp_addr_reg
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] cfg_q
);
  logic [DATA_W-1:0] cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ld) cfg_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/cfgp_validate.sv
module cfgp_validate
  import cfgp_pkg::*;
(
  input  logic                 win_hit,
  input  logic [1:0]           byte_sel,
  input  logic [LEN_W-1:0]     len,
  input  logic                 cfg_en,
  input  logic [1:0]           cfg_low,
  input  logic [BUS_W-1:0]     cfg_bus,
  input  logic [SLOT_W-1:0]    cfg_slot,
  input  logic [5:0]           cfg_dword,
  input  logic [NUM_SLOTS-1:0] present,
  output logic                 ok,
  output logic [OFF_W-1:0]     off
);
  logic len_ok;
  logic fits;
  logic [3:0] end_byte;

  always_comb begin
    len_ok   = (len == 3'd1) || (len == 3'd2) || (len == 3'd4);
    end_byte = {2'b00, byte_sel} + {1'b0, len};
    fits     = (end_byte <= 4'd4);
    ok       = win_hit && len_ok && fits && cfg_en && (cfg_low == 2'b00)
               && (cfg_bus == '0) && present[cfg_slot];
    off      = {cfg_dword, byte_sel};
  end
endmodule

// File: rtl/cfgp_fwd.sv
module cfgp_fwd
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              is_wr,
  input  logic [SLOT_W-1:0] slot,
  input  logic [OFF_W-1:0]  off,
  input  logic [LEN_W-1:0]  len,
  input  logic [DATA_W-1:0] wdata,
  output logic              tgt_req,
  output logic              tgt_wr,
  output logic [SLOT_W-1:0] tgt_slot,
  output logic [OFF_W-1:0]  tgt_off,
  output logic [LEN_W-1:0]  tgt_len,
  output logic [DATA_W-1:0] tgt_wdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tgt_req <= 1'b0;
    else        tgt_req <= go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_wr    <= 1'b0;
      tgt_slot  <= '0;
      tgt_off   <= '0;
      tgt_len   <= '0;
      tgt_wdata <= '0;
    end else if (go) begin
      tgt_wr    <= is_wr;
      tgt_slot  <= slot;
      tgt_off   <= off;
      tgt_len   <= len;
      tgt_wdata <= wdata;
    end
  end
endmodule

// File: rtl/cfgp_rsp.sv
module cfgp_rsp
  import cfgp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  rd_kind_e          kind_in,
  input  logic [DATA_W-1:0] snap_in,
  input  logic [DATA_W-1:0] tgt_rdata,
  output logic [DATA_W-1:0] io_rdata,
  output logic              io_rvalid
);
  rd_kind_e          kind_q;
  logic [DATA_W-1:0] snap_q;
  logic [DATA_W-1:0] rdata_d;
  logic              load1;

  always_comb begin
    load1 = (kind_in == RK_ADDR);
    case (kind_q)
      RK_ADDR:  rdata_d = snap_q;
      RK_CLAIM: rdata_d = tgt_rdata;
      default:  rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) kind_q <= RK_NONE;
    else        kind_q <= kind_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     snap_q <= '0;
    else if (load1) snap_q <= snap_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= (kind_q != RK_NONE);
      if (kind_q != RK_NONE) io_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/cfgp_decoder.sv
module cfgp_decoder
  import cfgp_pkg::*;
#(
  parameter int unsigned IO_AW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IO_AW-1:0]     io_addr,
  input  logic [DATA_W-1:0]    io_wdata,
  input  logic [LEN_W-1:0]     io_len,
  input  logic                 io_wr,
  input  logic                 io_rd,
  input  logic [NUM_SLOTS-1:0] slot_present,
  output logic [DATA_W-1:0]    io_rdata,
  output logic                 io_rvalid,
  output logic                 tgt_req,
  output logic                 tgt_wr,
  output logic [SLOT_W-1:0]    tgt_slot,
  output logic [OFF_W-1:0]     tgt_off,
  output logic [LEN_W-1:0]     tgt_len,
  output logic [DATA_W-1:0]    tgt_wdata,
  input  logic [DATA_W-1:0]    tgt_rdata
);
  localparam logic [IO_AW-1:0] ADDR_P = IO_AW'(ADDR_PORT);
  localparam logic [IO_AW-1:0] DATA_P = IO_AW'(DATA_PORT);

  logic [DATA_W-1:0] cfg_q;
  logic              addr_hit;
  logic              data_hit;
  logic              addr_ld;
  logic              rd_only;
  logic              acc_ok;
  logic              fwd_go;
  logic [OFF_W-1:0]  acc_off;
  rd_kind_e          rd_kind;

  always_comb begin
    addr_hit = (io_addr[IO_AW-1:2] == ADDR_P[IO_AW-1:2]);
    data_hit = (io_addr[IO_AW-1:2] == DATA_P[IO_AW-1:2]);
    addr_ld  = io_wr && (io_addr == ADDR_P) && (io_len == 3'd4);
    rd_only  = io_rd && !io_wr;
    fwd_go   = (io_wr || io_rd) && acc_ok;
    if (rd_only && addr_hit)      rd_kind = RK_ADDR;
    else if (rd_only && data_hit) rd_kind = acc_ok ? RK_CLAIM : RK_NULL;
    else                          rd_kind = RK_NONE;
  end

  cfgp_addr_reg u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .ld    (addr_ld),
    .wdata (io_wdata),
    .cfg_q (cfg_q)
  );

  cfgp_validate u_val (
    .win_hit   (data_hit),
    .byte_sel  (io_addr[1:0]),
    .len       (io_len),
    .cfg_en    (cfg_q[31]),
    .cfg_low   (cfg_q[1:0]),
    .cfg_bus   (cfg_q[23:16]),
    .cfg_slot  (cfg_q[15:8]),
    .cfg_dword (cfg_q[7:2]),
    .present   (slot_present),
    .ok        (acc_ok),
    .off       (acc_off)
  );

  cfgp_fwd u_fwd (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (fwd_go),
    .is_wr     (io_wr),
    .slot      (cfg_q[15:8]),
    .off       (acc_off),
    .len       (io_len),
    .wdata     (io_wdata),
    .tgt_req   (tgt_req),
    .tgt_wr    (tgt_wr),
    .tgt_slot  (tgt_slot),
    .tgt_off   (tgt_off),
    .tgt_len   (tgt_len),
    .tgt_wdata (tgt_wdata)
  );

  cfgp_rsp u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .kind_in   (rd_kind),
    .snap_in   (cfg_q),
    .tgt_rdata (tgt_rdata),
    .io_rdata  (io_rdata),
    .io_rvalid (io_rvalid)
  );
endmodule

// File: rtl/cfgp_decoder_chk.sv
module cfgp_decoder_chk #(
  parameter int unsigned IO_AW = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IO_AW-1:0] io_addr,
  input logic [2:0]       io_len,
  input logic             io_wr,
  input logic             io_rd,
  input logic [31:0]      cfg_q,
  input logic             tgt_req,
  input logic [7:0]       tgt_slot,
  input logic [7:0]       tgt_off,
  input logic             io_rvalid,
  input logic [31:0]      io_rdata
);
  logic in_win;
  assign in_win = (io_addr[IO_AW-1:2] == 14'h033F);

  a_r7_req_after_access: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> $past((io_wr || io_rd) && in_win));

  a_r4_req_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> $past(cfg_q[31]));

  a_r5_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> ($past(cfg_q[1:0]) == 2'b00));

  a_r6_req_bus_slot: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (($past(cfg_q[23:16]) == 8'h00) && (tgt_slot == $past(cfg_q[15:8]))));

  a_r7_offset: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_req |-> (tgt_off == {$past(cfg_q[7:2]), $past(io_addr[1:0])}));

  a_r2_partial_addr_write: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && (io_addr == 16'h0CF8) && (io_len != 3'd4)) |=> $stable(cfg_q));

  a_r10_rvalid_source: assert property (@(posedge clk) disable iff (!rst_n)
    io_rvalid |-> $past(io_rd && !io_wr, 2));

  a_r9_null_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rvalid && $past(in_win, 2) && !$past(tgt_req)) |-> (io_rdata == 32'h0));
endmodule

bind cfgp_decoder cfgp_decoder_chk #(.IO_AW(IO_AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .io_addr   (io_addr),
  .io_len    (io_len),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .cfg_q     (cfg_q),
  .tgt_req   (tgt_req),
  .tgt_slot  (tgt_slot),
  .tgt_off   (tgt_off),
  .io_rvalid (io_rvalid),
  .io_rdata  (io_rdata)
);

// File: tb/cfgp_decoder_bench.sv
module cfgp_decoder_bench;
  logic         clk;
  logic         rst_n;
  logic [15:0]  io_addr;
  logic [31:0]  io_wdata;
  logic [2:0]   io_len;
  logic         io_wr;
  logic         io_rd;
  logic [255:0] slot_present;
  logic [31:0]  io_rdata;
  logic         io_rvalid;
  logic         tgt_req;
  logic         tgt_wr;
  logic [7:0]   tgt_slot;
  logic [7:0]   tgt_off;
  logic [2:0]   tgt_len;
  logic [31:0]  tgt_wdata;
  logic [31:0]  tgt_rdata;

  int checks = 0;
  int fails  = 0;
  logic [31:0] model_cfg;

  typedef struct {
    logic        wr;
    logic [7:0]  slot;
    logic [7:0]  off;
    logic [2:0]  len;
    logic [31:0] data;
    string       tag;
  } tgt_exp_t;

  typedef struct {
    logic [31:0] data;
    string       tag;
  } rsp_exp_t;

  tgt_exp_t tq[$];
  rsp_exp_t rq[$];

  cfgp_decoder u_cfgp_decoder (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wdata(io_wdata),
    .io_len(io_len), .io_wr(io_wr), .io_rd(io_rd), .slot_present(slot_present),
    .io_rdata(io_rdata), .io_rvalid(io_rvalid), .tgt_req(tgt_req),
    .tgt_wr(tgt_wr), .tgt_slot(tgt_slot), .tgt_off(tgt_off),
    .tgt_len(tgt_len), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [31:0] tgt_word(logic [7:0] s, logic [7:0] o, logic [2:0] l);
    return {s, o, 8'h5A, 5'd0, l};
  endfunction

  assign tgt_rdata = tgt_req ? tgt_word(tgt_slot, tgt_off, tgt_len) : 32'hDEAD_BEEF;

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Driver: one access, expectations pushed from the requirement model.
  task automatic op(input bit wr, input bit rd, input logic [15:0] a,
                    input logic [31:0] d, input logic [2:0] l, input string tag);
    bit in_win, ok, len_ok;
    tgt_exp_t te;
    rsp_exp_t re;
    in_win = (a[15:2] == 14'h033F);
    len_ok = (l == 3'd1 || l == 3'd2 || l == 3'd4) && ({2'b0, a[1:0]} + {1'b0, l} <= 4'd4);
    ok = in_win && len_ok && model_cfg[31] && (model_cfg[1:0] == 2'b00) &&
         (model_cfg[23:16] == 8'h00) && slot_present[model_cfg[15:8]];
    if (ok && (wr || rd)) begin
      te.wr = wr; te.slot = model_cfg[15:8]; te.off = {model_cfg[7:2], a[1:0]};
      te.len = l; te.data = d; te.tag = tag;
      tq.push_back(te);
    end
    if (rd && !wr) begin
      re.tag = tag;
      if (a[15:2] == 14'h033E) begin
        re.data = model_cfg; rq.push_back(re);
      end else if (in_win) begin
        re.data = ok ? tgt_word(model_cfg[15:8], {model_cfg[7:2], a[1:0]}, l) : 32'h0;
        rq.push_back(re);
      end
    end
    if (wr && a == 16'h0CF8 && l == 3'd4) model_cfg = d;
    @(negedge clk);
    io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d; io_len = l;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (4) @(negedge clk);
    check(tq.size() == 0 && rq.size() == 0, tag, tq.size() + rq.size(), 0);
  endtask

  // Monitor: pops and compares as results appear.
  always @(negedge clk) begin
    if (rst_n) begin
      if (tgt_req) begin
        if (tq.size() == 0) check(1'b0, "R9 unexpected tgt_req", {24'h0, tgt_off}, 32'h0);
        else begin
          tgt_exp_t e;
          e = tq.pop_front();
          check(tgt_wr == e.wr && tgt_slot == e.slot && tgt_off == e.off &&
                tgt_len == e.len && (!e.wr || tgt_wdata == e.data),
                {e.tag, " R7 strobe"}, {tgt_slot, tgt_off, 5'd0, tgt_len, 7'd0, tgt_wr},
                {e.slot, e.off, 5'd0, e.len, 7'd0, e.wr});
        end
      end
      if (io_rvalid) begin
        if (rq.size() == 0) check(1'b0, "R10 unexpected io_rvalid", io_rdata, 32'h0);
        else begin
          rsp_exp_t e;
          e = rq.pop_front();
          check(io_rdata == e.data, e.tag, io_rdata, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; io_addr = '0; io_wdata = '0; io_len = '0; io_wr = 1'b0; io_rd = 1'b0;
    slot_present = '0;
    slot_present[8'h08] = 1'b1; slot_present[8'h11] = 1'b1; slot_present[8'h00] = 1'b1;
    model_cfg = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!io_rvalid && !tgt_req, "R1 reset outputs idle", {30'h0, io_rvalid, tgt_req}, 0);

    op(0, 1, 16'h0CF8, 0, 3'd4, "R1 reset value");
    op(1, 0, 16'h0CF8, 32'h8000_0810, 3'd4, "R1 load");
    op(0, 1, 16'h0CFA, 0, 3'd4, "R1 readback");
    op(1, 0, 16'h0CF8, 32'h0000_00FF, 3'd1, "R2 byte write");
    op(1, 0, 16'h0CF8, 32'h0000_FFFF, 3'd2, "R2 half write");
    op(0, 1, 16'h0CF8, 0, 3'd4, "R2 unchanged");
    drain("R2 drain");

    op(0, 1, 16'h0CFC, 0, 3'd4, "R8 dword read");
    op(1, 0, 16'h0CFE, 32'h0000_BEEF, 3'd2, "R7 half write off 2");
    op(0, 1, 16'h0CFF, 0, 3'd1, "R3 byte read off 3");
    drain("R7 drain");
    op(0, 1, 16'h0CFC, 0, 3'd3, "R3 illegal length");
    op(0, 1, 16'h0CFF, 0, 3'd2, "R3 straddle");
    op(1, 0, 16'h0CFD, 32'h1234_5678, 3'd4, "R3 write straddle");
    drain("R3 drain");

    op(1, 0, 16'h0CF8, 32'h0000_0810, 3'd4, "R4 clear enable");
    op(0, 1, 16'h0CFC, 0, 3'd4, "R4 read disabled");
    op(1, 0, 16'h0CFC, 32'hAAAA_5555, 3'd4, "R9 write disabled");
    drain("R4 drain");

    op(1, 0, 16'h0CF8, 32'h8000_0811, 3'd4, "R5 set low bit");
    op(0, 1, 16'h0CFC, 0, 3'd4, "R5 read misaligned");
    op(1, 0, 16'h0CFC, 32'h1, 3'd4, "R5 write misaligned");
    drain("R5 drain");

    op(1, 0, 16'h0CF8, 32'h8001_0810, 3'd4, "R6 bus one");
    op(0, 1, 16'h0CFC, 0, 3'd4, "R6 read bus one");
    op(1, 0, 16'h0CF8, 32'h8000_0910, 3'd4, "R6 absent slot");
    op(0, 1, 16'h0CFC, 0, 3'd4, "R6 read absent");
    op(1, 0, 16'h0CF8, 32'h8000_113C, 3'd4, "R6 slot 11");
    op(0, 1, 16'h0CFD, 0, 3'd1, "R6 read slot 11");
    drain("R6 drain");

    op(0, 1, 16'h0080, 0, 3'd4, "R10 foreign read");
    op(1, 1, 16'h0CFC, 32'hCAFE_F00D, 3'd4, "R10 rd and wr");
    drain("R10 drain");

    // R8 back-to-back reads with no idle cycle between them
    begin
      tgt_exp_t te;
      rsp_exp_t re;
      for (int i = 0; i < 2; i++) begin
        te.wr = 0; te.slot = 8'h11; te.off = 8'h3C + 8'(i); te.len = 3'd1;
        te.data = 0; te.tag = "R8 burst"; tq.push_back(te);
        re.data = tgt_word(8'h11, 8'h3C + 8'(i), 3'd1); re.tag = "R8 burst";
        rq.push_back(re);
      end
      @(negedge clk);
      io_rd = 1; io_addr = 16'h0CFC; io_len = 3'd1;
      @(negedge clk);
      io_addr = 16'h0CFD;
      @(negedge clk);
      io_rd = 0;
    end
    drain("R8 drain");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule